// File: doc/BRIEF.md
# Divided-Clock Idle Wake Controller

This block manages a low-activity idle state for a processor core. When the core requests idle, the controller stops its full-rate clock-enable strobe and replaces it with a slow strobe. The slow strobe fires once every n processor cycles, where n is 16, 32, 64 or 128. A plain idle mode with no division is also available; in that mode the strobe keeps firing every cycle. Interrupt lines are qualified by a per-line enable vector and are looked at only on strobe ticks. As a result, the delay before the core resumes grows with the chosen divisor.

An enabled interrupt that arrives between two ticks is latched as pending, so it cannot be missed. Leaving idle produces a single-cycle wake pulse, and the idle flag drops in that same cycle. The core uses the strobe as its clock enable, the idle flag as status, and the wake pulse to restart fetch. The clock gating cells, interrupt vectoring and the pipeline itself are outside this block.

Top module: `idle_wake_ctrl`

## Requirements
- R1: With div_en=1 the divisor follows div_sel: 2'b00=16, 2'b01=32, 2'b10=64, 2'b11=128. The value is captured on the clock edge that enters idle, and changes to div_sel or div_en during idle have no effect until the next entry.
- R2: With div_en=0 (plain idle), an enabled interrupt seen at a clock edge ends idle at that same edge. idle_o is low, and wake_o is high, in the following cycle.
- R3: Outside idle, after reset is released, clk_tick is high every cycle. In the cycle after the entry edge, clk_tick is low. During idle, clk_tick is high for one cycle after edge k (counting the entry edge as 0) exactly when k is a multiple of n.
- R4: An exit from idle happens only at an edge that produces a tick. The exit edge comes fewer than n edges after the first edge at which an enabled interrupt was seen.
- R5: A request line whose irq_en bit is 0 never causes an exit. It is also not remembered if its enable is set later, after the line has dropped.
- R6: An enabled interrupt seen for a single edge between ticks is held pending until the next tick, and it causes the exit there.
- R7: wake_o is high for exactly one cycle, and idle_o falls in that same cycle.
- R8: A synchronous active-high reset clears idle_o, wake_o, clk_tick, the pending interrupts and the divider count.
- R9: idle_req is ignored while idle or while wake_o is high. Interrupts seen before the entry edge, or at the entry edge itself, are not carried into the new idle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Request to enter idle |
| div_en | input | 1 | 1 selects divided idle, 0 selects plain idle |
| div_sel | input | 2 | Divisor select, captured at entry |
| irq | input | IRQ_W | Interrupt request lines |
| irq_en | input | IRQ_W | Per-line interrupt enable, 1 = enabled |
| clk_tick | output | 1 | Registered clock-enable strobe |
| idle_o | output | 1 | Idle status |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench targets the tick boundaries. An interrupt seen exactly on a tick edge must exit there, and one seen an edge later must wait a whole period. A design with an off-by-one counter, or one that ignores the pending latch, would miss the exit or add n cycles. The bench changes div_sel during idle, which catches a divisor that is not captured at entry. It also holds idle_req high across the wake pulse, which exposes re-entry in the wake cycle. Masked lines that are later unmasked, and interrupts already present at the entry edge, expose a pending latch that captures too much.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;

  // Divisor select codes; the value is the power-of-two step above the base divisor.
  typedef enum logic [1:0] {
    DIV_X16  = 2'b00,
    DIV_X32  = 2'b01,
    DIV_X64  = 2'b10,
    DIV_X128 = 2'b11
  } div_sel_e;

  function automatic int unsigned sel_step(input div_sel_e s);
    case (s)
      DIV_X16:  return 0;
      DIV_X32:  return 1;
      DIV_X64:  return 2;
      default:  return 3;
    endcase
  endfunction

endpackage

// File: rtl/idle_div_counter.sv
module idle_div_counter
  import idle_wake_pkg::*;
#(
  parameter int BASE_LOG = 4,
  localparam int CNT_W = BASE_LOG + 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       run,
  input  logic       div_en,
  input  logic [1:0] div_sel,
  output logic       at_lim,
  output logic       tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_sel;
  logic             tick_q;

  // Limit is n-1 = a run of ones, BASE_LOG+step wide; zero for plain idle.
  always_comb begin
    int unsigned width;
    width = BASE_LOG + sel_step(div_sel_e'(div_sel));
    for (int i = 0; i < CNT_W; i++) begin
      lim_sel[i] = div_en && (i < width);
    end
  end

  assign at_lim = (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      tick_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      lim_q  <= lim_sel;
      tick_q <= 1'b0;
    end else if (run) begin
      cnt_q  <= at_lim ? '0 : cnt_q + CNT_W'(1);
      tick_q <= at_lim;
    end else begin
      tick_q <= 1'b1;
    end
  end

  assign tick_o = tick_q;

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= lim_q));

  assert_lim_held_R1: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(lim_q));

endmodule

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             take,
  input  logic [IRQ_W-1:0] irq,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             hit
);

  logic [IRQ_W-1:0] pend_q;
  logic [IRQ_W-1:0] live;

  assign live = irq & irq_en;
  assign hit  = |(pend_q | live);

  always_ff @(posedge clk) begin
    if (rst || clr || take) begin
      pend_q <= '0;
    end else if (run) begin
      pend_q <= pend_q | live;
    end
  end

  assert_pend_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !take && !clr) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl #(
  parameter int IRQ_W    = 4,
  parameter int BASE_LOG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle_req,
  input  logic             div_en,
  input  logic [1:0]       div_sel,
  input  logic [IRQ_W-1:0] irq,
  input  logic [IRQ_W-1:0] irq_en,
  output logic             clk_tick,
  output logic             idle_o,
  output logic             wake_o
);

  logic idle_q;
  logic wake_q;
  logic start;
  logic take;
  logic at_lim;
  logic hit;

  assign start = idle_req && !idle_q && !wake_q;
  assign take  = idle_q && at_lim && hit;

  idle_div_counter #(.BASE_LOG(BASE_LOG)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (idle_q),
    .div_en  (div_en),
    .div_sel (div_sel),
    .at_lim  (at_lim),
    .tick_o  (clk_tick)
  );

  irq_pend_sampler #(.IRQ_W(IRQ_W)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .run    (idle_q),
    .take   (take),
    .irq    (irq),
    .irq_en (irq_en),
    .hit    (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= take;
      if (start)     idle_q <= 1'b1;
      else if (take) idle_q <= 1'b0;
    end
  end

  assign idle_o = idle_q;
  assign wake_o = wake_q;

  assert_wake_single_R7: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q);

  assert_idle_falls_with_wake_R7: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> (!idle_q && $past(idle_q)));

  assert_no_reentry_in_wake_R9: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !idle_q);

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (!idle_q && !wake_q));

endmodule

// File: tb/tb_idle_wake_ctrl.sv
`timescale 1ns/1ps
module tb_idle_wake_ctrl;

  localparam int IRQ_W = 4;
  localparam int NV = 9;
  localparam int T_EN  [NV] = '{0, 0, 1, 1, 1, 1, 1, 1, 1};
  localparam int T_SEL [NV] = '{0, 0, 0, 0, 0, 1, 2, 3, 3};
  localparam int T_D   [NV] = '{1, 5, 1, 16, 17, 3, 65, 1, 129};
  localparam int T_N   [NV] = '{1, 1, 16, 16, 16, 32, 64, 128, 128};
  localparam int T_W   [NV] = '{1, 5, 16, 16, 32, 32, 128, 128, 256};

  logic clk = 0;
  logic rst = 1;
  logic idle_req = 0;
  logic div_en = 0;
  logic [1:0] div_sel = 0;
  logic [IRQ_W-1:0] irq = 0;
  logic [IRQ_W-1:0] irq_en = '1;
  logic clk_tick, idle_o, wake_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  idle_wake_ctrl #(.IRQ_W(IRQ_W), .BASE_LOG(4)) dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .div_en(div_en),
    .div_sel(div_sel), .irq(irq), .irq_en(irq_en),
    .clk_tick(clk_tick), .idle_o(idle_o), .wake_o(wake_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Enter idle, pulse an enabled irq at edge d, change select after entry.
  task automatic run_idle(input int en, input int sel, input int sel_after,
                          input int d, input int n, input int w_exp, input string tag);
    int w;
    int ticks;
    w = 0; ticks = 0;
    div_en = en[0]; div_sel = sel[1:0]; idle_req = 1;
    step();
    idle_req = 0;
    div_sel = sel_after[1:0];
    check("R3 entry tick low", clk_tick, 0);
    for (int k = 1; k <= 300; k++) begin
      irq = (k == d) ? 4'b0100 : 4'b0000;
      step();
      irq = 0;
      if (clk_tick) ticks++;
      if (wake_o) begin
        w = k;
        break;
      end
    end
    check(tag, w, w_exp);
    check("R4 latency", (w - d < n) ? 1 : 0, 1);
    check("R3 tick count", ticks, w_exp / n);
    check("R7 idle low at wake", idle_o, 0);
    step();
    check("R7 wake single", wake_o, 0);
  endtask

  initial begin
    // R8: reset state
    step(); step();
    check("R8 idle", idle_o, 0);
    check("R8 wake", wake_o, 0);
    check("R8 tick", clk_tick, 0);
    rst = 0;
    step();
    check("R3 tick outside idle", clk_tick, 1);

    // Table of idle periods: R2 for plain, R4/R1 for divided
    for (int v = 0; v < NV; v++) begin
      run_idle(T_EN[v], T_SEL[v], T_SEL[v], T_D[v], T_N[v], T_W[v],
               (T_EN[v] == 0) ? "R2 plain exit" : "R4 divided exit");
    end

    // R1: select change during idle ignored
    run_idle(1, 0, 3, 2, 16, 16, "R1 select latched");
    // R6: single-edge pulse mid-period held pending
    run_idle(1, 1, 1, 10, 32, 32, "R6 pending held");

    // R5: masked lines never wake, not remembered after unmask
    div_en = 0; idle_req = 1; irq_en = 4'b0011;
    step();
    idle_req = 0;
    irq = 4'b1100;
    for (int k = 0; k < 10; k++) step();
    check("R5 masked idle", idle_o, 1);
    check("R5 masked wake", wake_o, 0);
    irq = 0; irq_en = 4'b1111;
    for (int k = 0; k < 5; k++) step();
    check("R5 not remembered", idle_o, 1);
    irq = 4'b0001;
    step();
    irq = 0;
    check("R2 wake after unmask", wake_o, 1);
    step();

    // R9: irq before and at entry not carried into idle
    irq = 4'b1000;
    step(); step();
    div_en = 1; div_sel = 0; idle_req = 1;
    step();
    idle_req = 0; irq = 0;
    for (int k = 0; k < 40; k++) step();
    check("R9 stale irq ignored", idle_o, 1);
    irq = 4'b0010;
    step();
    irq = 0;
    for (int k = 0; k < 20; k++) begin
      if (wake_o) break;
      step();
    end
    check("R9 exit after real irq", wake_o, 1);
    step();

    // R9: idle_req held across wake pulse
    div_en = 0; idle_req = 1;
    step();
    check("R9 entered", idle_o, 1);
    irq = 4'b0001;
    step();
    irq = 0;
    check("R7 wake", wake_o, 1);
    step();
    check("R9 no entry in wake cycle", idle_o, 0);
    step();
    check("R9 re-entry after wake", idle_o, 1);
    idle_req = 0;
    irq = 4'b0001;
    step();
    irq = 0;
    step();

    // R8: reset during divided idle
    div_en = 1; div_sel = 2'b11; idle_req = 1;
    step();
    idle_req = 0;
    for (int k = 0; k < 5; k++) step();
    rst = 1;
    step();
    check("R8 idle cleared", idle_o, 0);
    check("R8 tick cleared", clk_tick, 0);
    rst = 0;
    step();
    check("R3 tick after reset", clk_tick, 1);
    run_idle(1, 0, 0, 16, 16, 16, "R8 count cleared");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule